// File: doc/BRIEF.md
# Fully Associative Tag Directory with Switchable LRU/MRU Replacement

This block holds the tag and replacement state of a small fully associative cache that is addressed by word. It stores no data. Each cycle it can take one word-address reference. The block tag is compared against every valid entry at once, and the block reports a hit or a miss together with the entry that served the reference. On a miss it places the tag in the lowest-numbered empty entry. Only when every entry is occupied does it evict, and the run-time policy input picks the victim: the entry touched longest ago, or the entry touched most recently.

The cache capacity is `TOTAL_WORDS` words, and `BLOCK_WORDS` is 1 or 2 words per block. With the defaults (8 words, 2-word blocks) there are 4 entries. Address bit 0 is then the word offset, which plays no part in the match, and the 7-bit tag is `ref_addr[7:1]`. With 1-word blocks there are 8 entries and the whole 8-bit address is the tag. Each entry carries an age counter, and together the counters form an exact recency order. A debug port shows every tag and valid bit. Two saturating counters tally hits and misses.

The control is a two-state machine. `ST_IDLE` means no result is on the output. `ST_RESULT` means the result of the reference accepted on the previous edge is on the output. An accepted reference moves the machine from either state to `ST_RESULT` (transitions IDLE→RESULT and RESULT→RESULT). A cycle with nothing accepted moves it to `ST_IDLE` (RESULT→IDLE, IDLE→IDLE). Reset forces `ST_IDLE`.

Top module: `fa_tag_directory`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears every valid bit and every tag to zero, clears both counters, drops `res_valid`, and sets the entry ages to match their index (entry 0 youngest). `ref_ready` is high whenever `rst` is low.
- R2: With 2-word blocks the tag is `ref_addr[7:1]` and bit 0 is ignored, so addresses 0x03 and 0x02 hit the same entry. With 1-word blocks the tag is all 8 address bits.
- R3: On a hit, `res_hit`=1 and `res_entry` is the matching entry. No tag or valid bit changes, and `res_evict_valid`=0.
- R4: `res_valid` is high in exactly the cycle after a reference is accepted (`ref_valid && ref_ready` at the edge) and low otherwise.
- R5: On a miss while any entry is invalid, the lowest-numbered invalid entry is filled, `res_evict_valid`=0 and `res_evict_tag`=0. The policy input plays no part in this choice.
- R6: On a miss with all entries valid and `policy_mru`=0, the victim is the entry referenced longest ago.
- R7: On a miss with all entries valid and `policy_mru`=1, the victim is the entry referenced most recently.
- R8: Every hit and every fill makes the touched entry the most recent. The ages stay a permutation of 0..N-1.
- R9: On an eviction, `res_evict_valid`=1, `res_evict_tag` is the tag that was removed, and the new tag takes its place in the same entry.
- R10: `dbg_valid[i]` and `dbg_tags[i*TAG_W +: TAG_W]` show entry i, and they are updated at the same edge as the result.
- R11: `hit_count` and `miss_count` are 16 bits wide. Each increments on the matching outcome and holds at 65535.
- R12: `cnt_clear` zeroes both counters on the next edge and takes priority over a simultaneous increment.
- R13: At most one valid entry matches any tag, so valid tags are always distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference offered |
| ref_ready | output | 1 | Reference can be taken (high out of reset) |
| ref_addr | input | ADDR_W | Word address of the reference |
| policy_mru | input | 1 | Victim choice: 0 least recent, 1 most recent |
| cnt_clear | input | 1 | Zero both counters |
| res_valid | output | 1 | Result of the previous accepted reference is present |
| res_hit | output | 1 | Reference hit |
| res_entry | output | IDX_W | Entry that hit or was allocated |
| res_evict_valid | output | 1 | A valid tag was displaced |
| res_evict_tag | output | TAG_W | Displaced tag (0 when none) |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| dbg_valid | output | ENTRIES | Valid bit per entry |
| dbg_tags | output | ENTRIES*TAG_W | Tag per entry, entry i at bits i*TAG_W |

## Verification
Some properties are checked by assertions on every cycle. These are: the one-cycle result timing, that a hit matches at most one entry and leaves the tags untouched, that an eviction happens only when every entry was valid, that the ages remain a permutation, and how the counters saturate and clear. Other behaviour can only be shown by the bench scenarios, because it depends on the history of references: which entry LRU or MRU picks as the victim, that a hit ignores the offset bit, the fill order, and the exact tag contents after each reference. The bench follows the classic 14-address trace under both policies, plus a directed recency case, a long saturation run and a mixed random stream.

// File: rtl/fa_dir_pkg.sv
package fa_dir_pkg;
    typedef enum logic {
        POL_LRU = 1'b0,
        POL_MRU = 1'b1
    } policy_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fsm_e;

    typedef enum logic [1:0] {
        ACT_HIT   = 2'd0,
        ACT_FILL  = 2'd1,
        ACT_EVICT = 2'd2
    } act_e;
endpackage

// File: rtl/fa_match.sv
module fa_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 7,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES*TAG_W-1:0] tags_flat,
    input  logic [ENTRIES-1:0]       valid,
    input  logic [TAG_W-1:0]         probe,
    output logic [ENTRIES-1:0]       hit_vec,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic                     free_any,
    output logic [IDX_W-1:0]         free_idx
);
    // one comparator per entry, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags_flat[g*TAG_W +: TAG_W] == probe);
    end

    // descending scan so the lowest index wins
    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
            if (!valid[i])  free_idx = IDX_W'(i);
        end
    end

    assign hit      = |hit_vec;
    assign free_any = ~&valid;
endmodule

// File: rtl/fa_recency.sv
module fa_recency #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx,
    output logic [IDX_W-1:0] mru_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;
    logic [ENTRIES-1:0] seen;

    assign touched_age = age_q[touch_idx];

    // age 0 = most recent; younger-than-touched entries each grow one step older
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age_q[g] <= IDX_W'(g);
            end else if (touch) begin
                if (touch_idx == IDX_W'(g)) begin
                    age_q[g] <= '0;
                end else if (age_q[g] < touched_age) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        mru_idx = '0;
        seen    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == OLDEST) lru_idx = IDX_W'(i);
            if (age_q[i] == '0)     mru_idx = IDX_W'(i);
            seen[age_q[i]] = 1'b1;
        end
    end

    // R8: every age value occupied exactly once
    assert_age_permutation_R8: assert property (@(posedge clk) disable iff (rst)
        &seen);
endmodule

// File: rtl/fa_sat_counter.sv
module fa_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    assert_counter_holds_top_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == TOP && !$past(clear) && !$past(rst)) |-> count == TOP);

    assert_clear_wins_R12: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> count == '0);
endmodule

// File: rtl/fa_tag_directory.sv
module fa_tag_directory
    import fa_dir_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int TOTAL_WORDS = 8,
    parameter int BLOCK_WORDS = 2,
    parameter int CNT_W       = 16,
    localparam int ENTRIES    = TOTAL_WORDS / BLOCK_WORDS,
    localparam int OFF_W      = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 0,
    localparam int TAG_W      = ADDR_W - OFF_W,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ref_valid,
    output logic                     ref_ready,
    input  logic [ADDR_W-1:0]        ref_addr,
    input  logic                     policy_mru,
    input  logic                     cnt_clear,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [IDX_W-1:0]         res_entry,
    output logic                     res_evict_valid,
    output logic [TAG_W-1:0]         res_evict_tag,
    output logic [CNT_W-1:0]         hit_count,
    output logic [CNT_W-1:0]         miss_count,
    output logic [ENTRIES-1:0]       dbg_valid,
    output logic [ENTRIES*TAG_W-1:0] dbg_tags
);
    fsm_e    st_q, st_d;
    policy_e pol;
    act_e    act;

    logic                     accept;
    logic [TAG_W-1:0]         probe_tag;
    logic [TAG_W-1:0]         tag_q [ENTRIES];
    logic [ENTRIES-1:0]       valid_q;
    logic [ENTRIES*TAG_W-1:0] tags_flat;
    logic [ENTRIES-1:0]       hit_vec;
    logic                     hit;
    logic [IDX_W-1:0]         hit_idx, free_idx, lru_idx, mru_idx, sel_idx;
    logic                     free_any;

    assign ref_ready = !rst;
    assign accept    = ref_valid && ref_ready;
    assign probe_tag = ref_addr[ADDR_W-1:OFF_W];
    assign pol       = policy_e'(policy_mru);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
    end
    assign dbg_tags  = tags_flat;
    assign dbg_valid = valid_q;

    fa_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .tags_flat (tags_flat),
        .valid     (valid_q),
        .probe     (probe_tag),
        .hit_vec   (hit_vec),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .free_any  (free_any),
        .free_idx  (free_idx)
    );

    fa_recency #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_recency (
        .clk       (clk),
        .rst       (rst),
        .touch     (accept),
        .touch_idx (sel_idx),
        .lru_idx   (lru_idx),
        .mru_idx   (mru_idx)
    );

    // allocation decision: hit, then empty slot, then policy victim
    always_comb begin
        if (hit) begin
            act     = ACT_HIT;
            sel_idx = hit_idx;
        end else if (free_any) begin
            act     = ACT_FILL;
            sel_idx = free_idx;
        end else begin
            act     = ACT_EVICT;
            sel_idx = (pol == POL_MRU) ? mru_idx : lru_idx;
        end
    end

    // state register
    always_comb begin
        unique case (st_q)
            ST_IDLE:   st_d = accept ? ST_RESULT : ST_IDLE;
            ST_RESULT: st_d = accept ? ST_RESULT : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // outputs
    always_comb begin
        res_valid = (st_q == ST_RESULT);
    end

    // directory contents and registered result
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q         <= '0;
            res_hit         <= 1'b0;
            res_entry       <= '0;
            res_evict_valid <= 1'b0;
            res_evict_tag   <= '0;
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
        end else if (accept) begin
            res_hit         <= (act == ACT_HIT);
            res_entry       <= sel_idx;
            res_evict_valid <= (act == ACT_EVICT);
            res_evict_tag   <= (act == ACT_EVICT) ? tag_q[sel_idx] : '0;
            if (act != ACT_HIT) begin
                tag_q[sel_idx]   <= probe_tag;
                valid_q[sel_idx] <= 1'b1;
            end
        end
    end

    fa_sat_counter #(.W(CNT_W)) u_hits (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (accept && hit),
        .count (hit_count)
    );

    fa_sat_counter #(.W(CNT_W)) u_misses (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (accept && !hit),
        .count (miss_count)
    );

    assert_single_match_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_result_timing_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid == $past(ref_valid && ref_ready));

    assert_hit_no_evict_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> !res_evict_valid);

    assert_hit_keeps_tags_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> (dbg_tags == $past(dbg_tags) && dbg_valid == $past(dbg_valid)));

    assert_evict_only_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_evict_valid) |-> &$past(dbg_valid));
endmodule

// File: tb/sim_fa_tag_directory.sv
`timescale 1ns/1ps
module sim_fa_tag_directory;
    localparam int ADDR_W = 8;
    localparam int TOTAL  = 8;
    localparam int BLK    = 2;
    localparam int N      = TOTAL / BLK;
    localparam int OFF    = 1;
    localparam int TAG_W  = ADDR_W - OFF;
    localparam int IDX_W  = 2;
    localparam int CMAX   = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_valid = 1'b0;
    logic ref_ready;
    logic [ADDR_W-1:0] ref_addr = '0;
    logic policy_mru = 1'b0;
    logic cnt_clear = 1'b0;
    logic res_valid, res_hit, res_evict_valid;
    logic [IDX_W-1:0] res_entry;
    logic [TAG_W-1:0] res_evict_tag;
    logic [15:0] hit_count, miss_count;
    logic [N-1:0] dbg_valid;
    logic [N*TAG_W-1:0] dbg_tags;

    always #2.5 clk = ~clk;

    fa_tag_directory #(.ADDR_W(ADDR_W), .TOTAL_WORDS(TOTAL), .BLOCK_WORDS(BLK), .CNT_W(16)) u0 (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_ready(ref_ready),
        .ref_addr(ref_addr), .policy_mru(policy_mru), .cnt_clear(cnt_clear),
        .res_valid(res_valid), .res_hit(res_hit), .res_entry(res_entry),
        .res_evict_valid(res_evict_valid), .res_evict_tag(res_evict_tag),
        .hit_count(hit_count), .miss_count(miss_count),
        .dbg_valid(dbg_valid), .dbg_tags(dbg_tags)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model
    int mtag [N];
    bit mval [N];
    int rq [$];
    int e_valid, e_hit, e_entry, e_evv, e_evt, e_hc, e_mc;
    string e_kind;

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        rq.delete();
        for (int i = 0; i < N; i++) begin
            mtag[i] = 0;
            mval[i] = 0;
            rq.push_back(i);
        end
        e_valid = 0; e_hit = 0; e_entry = 0; e_evv = 0; e_evt = 0;
        e_hc = 0; e_mc = 0; e_kind = "R1";
    endfunction

    function automatic void model_step(bit v, int addr, bit pol, bit clr);
        int tag, e, k;
        bit h;
        e_valid = v;
        if (v) begin
            tag = addr >> OFF;
            h = 0; e = -1; e_evv = 0; e_evt = 0;
            for (int i = 0; i < N; i++) if (mval[i] && mtag[i] == tag) begin h = 1; e = i; end
            if (h) e_kind = "R3";
            else begin
                for (int i = N - 1; i >= 0; i--) if (!mval[i]) e = i;
                if (e >= 0) e_kind = "R5";
                else begin
                    e = pol ? rq[0] : rq[rq.size() - 1];
                    e_kind = pol ? "R7" : "R6";
                    e_evv = 1;
                    e_evt = mtag[e];
                end
                mtag[e] = tag;
                mval[e] = 1;
            end
            e_hit = h;
            e_entry = e;
            k = 0;
            for (int i = 0; i < rq.size(); i++) if (rq[i] == e) k = i;
            rq.delete(k);
            rq.push_front(e);
        end
        if (clr) begin
            e_hc = 0; e_mc = 0;
        end else if (v) begin
            if (e_hit != 0) begin if (e_hc < CMAX) e_hc++; end
            else begin if (e_mc < CMAX) e_mc++; end
        end
    endfunction

    task automatic compare_all();
        check("R4", "res_valid", int'(res_valid), e_valid);
        if (e_valid != 0) begin
            check(e_kind, "res_hit", int'(res_hit), e_hit);
            check(e_kind, "res_entry", int'(res_entry), e_entry);
            check("R9", "res_evict_valid", int'(res_evict_valid), e_evv);
            check("R9", "res_evict_tag", int'(res_evict_tag), e_evt);
        end
        check("R11", "hit_count", int'(hit_count), e_hc);
        check("R11", "miss_count", int'(miss_count), e_mc);
        for (int i = 0; i < N; i++) begin
            check("R10", "dbg_valid", int'(dbg_valid[i]), int'(mval[i]));
            check("R10", "dbg_tag", int'(dbg_tags[i*TAG_W +: TAG_W]), mtag[i]);
            for (int j = i + 1; j < N; j++)
                if (dbg_valid[i] && dbg_valid[j])
                    check("R13", "distinct tags", int'(dbg_tags[i*TAG_W +: TAG_W] != dbg_tags[j*TAG_W +: TAG_W]), 1);
        end
    endtask

    task automatic cyc(bit v, int addr, bit pol, bit clr);
        @(negedge clk);
        compare_all();
        ref_valid  = v;
        ref_addr   = ADDR_W'(addr);
        policy_mru = pol;
        cnt_clear  = clr;
        model_step(v, addr, pol, clr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_valid = 1'b0; cnt_clear = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    function automatic int trace_addr(int i);
        case (i)
            0: return 'h03;  1: return 'hb4;  2: return 'h2b;  3: return 'h02;
            4: return 'hbe;  5: return 'h58;  6: return 'hbf;  7: return 'h0e;
            8: return 'h1f;  9: return 'hb5; 10: return 'hbf; 11: return 'hba;
            12: return 'h2e; default: return 'hce;
        endcase
    endfunction

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'h5a;
        do_reset();
        // R1: reset state
        cyc(0, 0, 0, 0);
        check("R1", "ref_ready", int'(ref_ready), 1);
        check("R1", "res_valid", int'(res_valid), 0);
        check("R1", "dbg_valid", int'(dbg_valid), 0);

        // R2: offset bit ignored
        cyc(1, 'h03, 0, 0);
        cyc(1, 'h02, 0, 0);
        cyc(0, 0, 0, 0);
        check("R2", "0x02 hits 0x03 block", int'(res_hit), 1);
        check("R2", "entry", int'(res_entry), 0);

        // trace under least-recent policy
        for (int i = 0; i < 14; i++) cyc(1, trace_addr(i), 0, 0);
        cyc(0, 0, 0, 0);

        // trace under most-recent policy
        do_reset();
        for (int i = 0; i < 14; i++) cyc(1, trace_addr(i), 1, 0);
        cyc(0, 0, 1, 0);

        // R8 / R6 / R7 directed recency case
        do_reset();
        cyc(1, 'h10, 0, 0);
        cyc(1, 'h20, 0, 0);
        cyc(1, 'h30, 0, 0);
        cyc(1, 'h40, 0, 0);
        cyc(1, 'h10, 0, 0);
        cyc(1, 'h50, 0, 0);
        cyc(0, 0, 0, 0);
        check("R8", "hit promoted entry0, victim", int'(res_entry), 1);
        check("R6", "evicted tag", int'(res_evict_tag), 'h20 >> 1);
        cyc(1, 'h60, 1, 0);
        cyc(0, 0, 1, 0);
        check("R7", "most recent victim", int'(res_entry), 1);
        check("R7", "evicted tag", int'(res_evict_tag), 'h50 >> 1);

        // R12: clear with simultaneous reference
        cyc(1, 'h60, 0, 1);
        cyc(0, 0, 0, 0);
        check("R12", "hit_count after clear", int'(hit_count), 0);
        check("R12", "miss_count after clear", int'(miss_count), 0);

        // R11: saturation
        for (int i = 0; i < CMAX + 5; i++) cyc(1, 'h60, 0, 0);
        cyc(0, 0, 0, 0);
        check("R11", "hit_count saturated", int'(hit_count), CMAX);
        check("R11", "miss_count unchanged", int'(miss_count), 0);

        // mixed random stream
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0] | lfsr[1], int'(lfsr[4:1]) * 3, lfsr[6], (i % 97) == 50);
        end
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule